// File: doc/BRIEF.md
# SPI Master Clock and Delay Sequencer

This block times one frame of an SPI master from the system bus clock. A frame runs through four phases in a fixed order. First comes a settling delay between chip-select assertion and the first clock edge. Then the serial clock toggles once per bit, and an after-clock delay follows the last edge. A final idle gap closes the frame before chip select may be driven again. The neighbouring shifter owns the data and the SCK pin. It raises `start` to open a frame. It then shifts on the leading and trailing edge strobes and uses the phase-done strobes to drive chip select.

Every timing is a product of two factors. A 2-bit prescaler code picks a factor of 2, 3, 5 or 7. A 4-bit scaler code picks a factor from a fixed table. The serial clock uses a mixed table of 2, 4, 6, 8 and then powers of two up to 32768, and it has an optional double-rate mode that halves the period. The three delays use a pure power-of-two scaler. The configuration word is captured when a frame opens and held for the whole frame. Selecting the best divider pair is left to software.

Top module: `spi_timing_gen`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `busy` and all six strobes are low.
- R2: A `start` sampled high while `busy` is low captures `cfg` and raises `busy` from the next cycle. A `start` seen while `busy` is high is ignored.
- R3: The settling phase lasts p × 2^(s+1) cycles. Here p is the prescaler factor selected by `cfg[23:22]`, with codes 0,1,2,3 giving 2,3,5,7, and s = `cfg[15:12]`. `csd_done` is high in its last cycle only.
- R4: The clock period P is p × q bus cycles. Here p is selected by `cfg[17:16]` (same codes as R3), and q is selected by `cfg[3:0]`: codes 0..2 give 2,4,6, and code n ≥ 3 gives 2^n. When `cfg[31]` is 1, P is halved.
- R5: Each bit spends ceil(P/2) cycles in the idle level and ends that half with `sck_lead`. It then spends floor(P/2) cycles in the active level and ends that half with `sck_trail`, so an odd P makes the active half one cycle shorter.
- R6: A frame has f+1 bits, where f = `cfg[30:27]`. `clk_done` is high exactly with the last `sck_trail`.
- R7: The after-clock phase follows the last bit and lasts p × 2^(s+1) cycles, with p from `cfg[21:20]` and s = `cfg[11:8]`. `asc_done` is high in its last cycle.
- R8: The idle gap follows and lasts p × 2^(s+1) cycles, with p from `cfg[19:18]` and s = `cfg[7:4]`. `dat_done` is high in its last cycle, and `busy` falls in the next cycle.
- R9: Changes on `cfg` while `busy` is high have no effect on the running frame.
- R10: At most one of `csd_done`, `sck_lead`, `sck_trail`, `asc_done` and `dat_done` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a frame when idle |
| cfg | input | 32 | Timing configuration word |
| busy | output | 1 | Frame in progress |
| csd_done | output | 1 | Last cycle of chip-select-to-clock delay |
| sck_lead | output | 1 | End of idle-level half: leading clock edge |
| sck_trail | output | 1 | End of active-level half: trailing clock edge |
| clk_done | output | 1 | Last trailing edge of the frame |
| asc_done | output | 1 | Last cycle of after-clock delay |
| dat_done | output | 1 | Last cycle of inter-frame gap |

## Verification
The bench builds the block with the default counter width of 19 bits. That width covers the longest possible delay, 7 × 65536 cycles. Random frames use every prescaler code but keep the scaler codes small, so each frame's whole strobe schedule is compared cycle by cycle. Directed frames cover the 2-cycle and 3-cycle clock of double-rate mode, single-bit and 16-bit frames, and configuration and start noise injected mid-frame.

// File: rtl/spi_timing_gen.sv
module spi_timing_gen #(
  parameter int CNT_W = 19
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] cfg,
  output logic        busy,
  output logic        csd_done,
  output logic        sck_lead,
  output logic        sck_trail,
  output logic        clk_done,
  output logic        asc_done,
  output logic        dat_done
);

  typedef enum logic [2:0] {S_IDLE, S_CSD, S_CLK, S_ASC, S_DAT} phase_t;

  phase_t             st;
  logic [CNT_W-1:0]   cnt;
  logic               half;
  logic [3:0]         bits;
  logic [31:0]        cfg_q;
  logic [CNT_W-1:0]   period, lo_len, hi_len, asc_len, dat_len;
  logic               unused_cfg;

  function automatic logic [CNT_W-1:0] pre_fac(input logic [1:0] c);
    case (c)
      2'd0:    return CNT_W'(2);
      2'd1:    return CNT_W'(3);
      2'd2:    return CNT_W'(5);
      default: return CNT_W'(7);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] dly_len(input logic [1:0] p, input logic [3:0] s);
    return pre_fac(p) << (32'(s) + 1);
  endfunction

  function automatic logic [CNT_W-1:0] baud_sc(input logic [3:0] s);
    if (s < 4'd3) return CNT_W'(2 * (32'(s) + 1));
    return CNT_W'(1) << s;
  endfunction

  function automatic logic [CNT_W-1:0] baud_per(input logic [31:0] w);
    logic [CNT_W-1:0] full;
    full = pre_fac(w[17:16]) * baud_sc(w[3:0]);
    return w[31] ? (full >> 1) : full;
  endfunction

  assign unused_cfg = ^cfg_q[26:24];
  assign period  = baud_per(cfg_q);
  assign hi_len  = period >> 1;
  assign lo_len  = period - hi_len;
  assign asc_len = dly_len(cfg_q[21:20], cfg_q[11:8]);
  assign dat_len = dly_len(cfg_q[19:18], cfg_q[7:4]);

  wire last = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      half  <= 1'b0;
      bits  <= '0;
      cfg_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          cfg_q <= cfg;
          cnt   <= dly_len(cfg[23:22], cfg[15:12]) - 1'b1;
          st    <= S_CSD;
        end
        S_CSD: if (last) begin
          st   <= S_CLK;
          half <= 1'b0;
          bits <= cfg_q[30:27];
          cnt  <= lo_len - 1'b1;
        end else cnt <= cnt - 1'b1;
        S_CLK: if (last) begin
          if (!half) begin
            half <= 1'b1;
            cnt  <= hi_len - 1'b1;
          end else if (bits == '0) begin
            st  <= S_ASC;
            cnt <= asc_len - 1'b1;
          end else begin
            bits <= bits - 1'b1;
            half <= 1'b0;
            cnt  <= lo_len - 1'b1;
          end
        end else cnt <= cnt - 1'b1;
        S_ASC: if (last) begin
          st  <= S_DAT;
          cnt <= dat_len - 1'b1;
        end else cnt <= cnt - 1'b1;
        S_DAT: if (last) st <= S_IDLE;
               else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign csd_done  = (st == S_CSD) && last;
  assign sck_lead  = (st == S_CLK) && last && !half;
  assign sck_trail = (st == S_CLK) && last && half;
  assign clk_done  = sck_trail && (bits == '0);
  assign asc_done  = (st == S_ASC) && last;
  assign dat_done  = (st == S_DAT) && last;

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({csd_done, sck_lead, sck_trail, asc_done, dat_done}));

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R8
  gap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_done |=> !busy);

  // R6
  last_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_done |=> !sck_lead && !sck_trail);

  // R3
  csd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csd_done |=> !csd_done);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg_q));

endmodule

// File: tb/sim_spi_timing_gen.sv
module sim_spi_timing_gen;
  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] cfg = '0;
  logic busy, csd_done, sck_lead, sck_trail, clk_done, asc_done, dat_done;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  spi_timing_gen u0 (.clk(clk), .rst_n(rst_n), .start(start), .cfg(cfg), .busy(busy),
    .csd_done(csd_done), .sck_lead(sck_lead), .sck_trail(sck_trail), .clk_done(clk_done),
    .asc_done(asc_done), .dat_done(dat_done));

  function automatic int pf(input logic [1:0] c);
    return (c == 0) ? 2 : (c == 1) ? 3 : (c == 2) ? 5 : 7;
  endfunction
  function automatic int dl(input logic [1:0] p, input logic [3:0] s);
    return pf(p) * (2 ** (s + 1));
  endfunction
  function automatic int bp(input logic [31:0] w);
    int q = (w[3:0] < 3) ? 2 * (w[3:0] + 1) : 2 ** w[3:0];
    int p = pf(w[17:16]) * q;
    return w[31] ? p / 2 : p;
  endfunction

  task automatic chk(input string req, input string nm, input int bad, input int cyc,
                     input logic got, input logic exp);
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s %s: cycle %0d got %0b expected %0b", req, nm, cyc, got, exp);
    end
  endtask

  task automatic run_frame(input logic [31:0] w, input bit noise);
    int L, P, lo, N, La, Ld, tot, first_bad[8];
    logic gotv[8], expv[8];
    int bad[8];
    string rq[8], nm[8];
    L = dl(w[23:22], w[15:12]); P = bp(w); lo = P - P / 2; N = w[30:27] + 1;
    La = dl(w[21:20], w[11:8]); Ld = dl(w[19:18], w[7:4]);
    tot = L + N * P + La + Ld;
    rq = '{"R2", "R3", "R5", "R4", "R6", "R7", "R8", "R10"};
    nm = '{"busy", "csd_done", "sck_lead", "sck_trail", "clk_done", "asc_done", "dat_done", "excl"};
    for (int k = 0; k < 8; k++) begin bad[k] = 0; first_bad[k] = -1; end
    @(negedge clk); start = 1; cfg = w;
    @(negedge clk); start = 0;
    for (int r = 0; r <= tot; r++) begin
      logic e[8], g[8];
      int q, m;
      q = r - L; m = (q >= 0) ? q % P : 0;
      e[0] = (r < tot);
      e[1] = (r == L - 1);
      e[2] = (q >= 0) && (q < N * P) && (m == lo - 1);
      e[3] = (q >= 0) && (q < N * P) && (m == P - 1);
      e[4] = (q == N * P - 1);
      e[5] = (r == L + N * P + La - 1);
      e[6] = (r == tot - 1);
      e[7] = 1'b1;
      g = '{busy, csd_done, sck_lead, sck_trail, clk_done, asc_done, dat_done,
            ($countones({csd_done, sck_lead, sck_trail, asc_done, dat_done}) <= 1)};
      for (int k = 0; k < 8; k++)
        if (g[k] !== e[k] && bad[k] == 0) begin
          bad[k] = 1; first_bad[k] = r; gotv[k] = g[k]; expv[k] = e[k];
        end
      if (noise && (r == L / 2 || r == L + P)) begin start = 1; cfg = $urandom; end
      else start = 0;
      @(negedge clk);
    end
    start = 0;
    for (int k = 0; k < 8; k++)
      chk(noise ? {"R9/", rq[k]} : rq[k], nm[k], bad[k], first_bad[k], gotv[k], expv[k]);
  endtask

  function automatic logic [31:0] mk(input bit dbl, input logic [3:0] f,
      input logic [1:0] pc, input logic [1:0] pa, input logic [1:0] pd, input logic [1:0] pb,
      input logic [3:0] sc, input logic [3:0] sa, input logic [3:0] sd, input logic [3:0] sb);
    return {dbl, f, 3'b000, pc, pa, pd, pb, sc, sa, sd, sb};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", "reset outputs", {busy, csd_done, sck_lead, sck_trail, clk_done, asc_done, dat_done} != 0,
        0, |{busy, csd_done, sck_lead, sck_trail, clk_done, asc_done, dat_done}, 1'b0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "post-reset outputs", {busy, csd_done, sck_lead, sck_trail, clk_done, asc_done, dat_done} != 0,
        1, |{busy, csd_done, sck_lead, sck_trail, clk_done, asc_done, dat_done}, 1'b0);
    // R4 R5 double rate, period 2
    run_frame(mk(1, 4'd7, 0, 0, 0, 0, 0, 0, 0, 0), 0);
    // R4 R5 double rate, odd period 3
    run_frame(mk(1, 4'd5, 1, 2, 3, 1, 1, 0, 2, 0), 0);
    // R6 single bit and sixteen bits
    run_frame(mk(0, 4'd0, 3, 1, 2, 2, 2, 1, 0, 3), 0);
    run_frame(mk(0, 4'd15, 0, 3, 1, 3, 0, 2, 1, 1), 0);
    // R9 start and cfg noise while busy
    run_frame(mk(0, 4'd3, 2, 2, 2, 1, 3, 3, 3, 2), 1);
    run_frame(mk(1, 4'd9, 3, 0, 1, 3, 2, 1, 1, 4), 1);
    for (int i = 0; i < 24; i++) begin
      logic [31:0] w;
      w = mk(1'($urandom), 4'($urandom), 2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
             4'($urandom % 5), 4'($urandom % 5), 4'($urandom % 5), 4'($urandom % 5));
      run_frame(w, (i % 4) == 3);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule